// File: doc/BRIEF.md
# Card Host Error Interrupt Collector

This block gathers the error and event indications of a memory-card host controller into one set of sticky status bits. Each of eight sources delivers a one-cycle pulse when its condition occurs. The pulse sets the matching status bit, and the bit holds until software acknowledges it. A per-source enable decides which pending bits raise the level-sensitive error interrupt.

The same enabled-error condition also produces a single-cycle terminate pulse for the DMA engine, so that a transfer in progress stops as soon as the first enabled error appears. The DMA engine itself lies outside this block.

Software uses a small write port with two addresses. One address loads the enable register. The other is a write-one-to-clear alias that acknowledges the status bits selected by the written mask.

Top module: `err_irq_collector`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, status reads 0, the enable register reads 0xFE, and both irq_o and dma_term_o are 0.
- R2: A pulse on source line i sets status bit i on the next clock edge, whatever the enable bit. The bit order is: 0 card-interrupt (SDIO), 1 response error, 2 response timeout, 3 data timeout, 4 data CRC, 5 FIFO underrun, 6 receive timeout, 7 FIFO overrun.
- R3: A status bit stays set after its source pulse ends, until a clear write selects it.
- R4: irq_o is high whenever a status bit and its enable bit are both set, and it stays high until those bits are cleared or disabled.
- R5: A pending status bit whose enable bit is 0 raises neither irq_o nor dma_term_o. Out of reset this applies to the card-interrupt source, bit 0.
- R6: dma_term_o is a one-cycle pulse, issued when the combined enabled-error signal goes from 0 to 1. A further error that arrives while that signal is already high gives no second pulse.
- R7: A write to address 1 clears every status bit whose data bit is 1, and leaves the bits whose data bit is 0 unchanged.
- R8: When a source pulse and a clear of the same bit fall in one cycle, the bit ends up set.
- R9: A write to address 0 replaces the enable register with the written data. Enabling a bit that is already pending raises irq_o and produces a dma_term_o pulse.
- R10: Writes to addresses 2 and 3 change neither the status nor the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | One-cycle event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 loads the enable register, 1 is the clear alias |
| wr_data_i | input | 8 | Write data: the enable value or the clear mask |
| status_o | output | 8 | Sticky status readback |
| enable_o | output | 8 | Enable register readback |
| irq_o | output | 1 | Level error interrupt |
| dma_term_o | output | 1 | One-cycle DMA terminate pulse |

## Verification
Each event, clear or enable write is captured at one clock edge. The new status, enable, irq_o and dma_term_o values are all visible right after that same edge, because the outputs are built from the flops with no further register on the way. dma_term_o falls again after the following edge. The bench drives every stimulus on the falling edge and samples 1 ns after the next rising edge. It then takes one idle cycle and checks that the terminate pulse has dropped while status and irq_o hold.

// File: rtl/err_coll_pkg.sv
package err_coll_pkg;

    localparam int SRC_COUNT  = 8;
    localparam int ADDR_BITS  = 2;
    localparam int ADDR_ENABLE = 0;
    localparam int ADDR_CLEAR  = 1;

    // Bit position of each source in status and enable.
    typedef enum logic [2:0] {
        SRC_CARD_IRQ   = 3'd0,
        SRC_RESP_ERR   = 3'd1,
        SRC_RESP_TMO   = 3'd2,
        SRC_DATA_TMO   = 3'd3,
        SRC_DATA_CRC   = 3'd4,
        SRC_FIFO_UNDER = 3'd5,
        SRC_RX_TMO     = 3'd6,
        SRC_FIFO_OVER  = 3'd7
    } err_src_e;

    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_ENABLE = 2'd1,
        WR_CLEAR  = 2'd2
    } wr_op_e;

    typedef struct packed {
        wr_op_e                op;
        logic [SRC_COUNT-1:0]  data;
    } wr_cmd_t;

    // Every source enabled except the card-interrupt line.
    function automatic logic [SRC_COUNT-1:0] default_enable();
        logic [SRC_COUNT-1:0] v;
        v = '1;
        v[SRC_CARD_IRQ] = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/err_wr_decode.sv
module err_wr_decode
    import err_coll_pkg::*;
#(
    parameter int NSRC   = SRC_COUNT,
    parameter int ADDR_W = ADDR_BITS
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [NSRC-1:0]   wr_data_i,
    output wr_op_e            op_o,
    output logic [NSRC-1:0]   data_o
);

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ADDR_ENABLE);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADDR_CLEAR);

    always_comb begin
        op_o   = WR_NONE;
        data_o = wr_data_i;
        if (wr_en_i) begin
            if (wr_addr_i == A_EN)
                op_o = WR_ENABLE;
            else if (wr_addr_i == A_CLR)
                op_o = WR_CLEAR;
        end
    end

endmodule

// File: rtl/err_enable_reg.sv
module err_enable_reg
    import err_coll_pkg::*;
#(
    parameter int              NSRC     = SRC_COUNT,
    parameter logic [NSRC-1:0] EN_RESET = default_enable()
) (
    input  logic            clk,
    input  logic            rst,
    input  wr_op_e          op_i,
    input  logic [NSRC-1:0] data_i,
    output logic [NSRC-1:0] en_o
);

    always_ff @(posedge clk) begin
        if (rst)
            en_o <= EN_RESET;
        else if (op_i == WR_ENABLE)
            en_o <= data_i;
    end

endmodule

// File: rtl/err_status_bank.sv
module err_status_bank
    import err_coll_pkg::*;
#(
    parameter int NSRC = SRC_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt_i,
    input  wr_op_e          op_i,
    input  logic [NSRC-1:0] data_i,
    output logic [NSRC-1:0] status_o
);

    logic [NSRC-1:0] clr_mask;

    assign clr_mask = (op_i == WR_CLEAR) ? data_i : '0;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // A new event has priority over an acknowledge in the same cycle.
        always_ff @(posedge clk) begin
            if (rst)
                status_o[i] <= 1'b0;
            else if (evt_i[i])
                status_o[i] <= 1'b1;
            else if (clr_mask[i])
                status_o[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/err_irq_gen.sv
module err_irq_gen
    import err_coll_pkg::*;
#(
    parameter int NSRC = SRC_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] status_i,
    input  logic [NSRC-1:0] en_i,
    output logic            irq_o,
    output logic            term_o
);

    logic hit;
    logic hit_q;

    assign hit = |(status_i & en_i);

    always_ff @(posedge clk) begin
        if (rst)
            hit_q <= 1'b0;
        else
            hit_q <= hit;
    end

    assign irq_o  = hit;
    assign term_o = hit & ~hit_q;

endmodule

// File: rtl/err_irq_collector.sv
module err_irq_collector
    import err_coll_pkg::*;
#(
    parameter int              NSRC     = SRC_COUNT,
    parameter int              ADDR_W   = ADDR_BITS,
    parameter logic [NSRC-1:0] EN_RESET = default_enable()
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [NSRC-1:0]   wr_data_i,
    output logic [NSRC-1:0]   status_o,
    output logic [NSRC-1:0]   enable_o,
    output logic              irq_o,
    output logic              dma_term_o
);

    wr_op_e          op;
    logic [NSRC-1:0] wdata;

    err_wr_decode #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_dec (
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .op_o      (op),
        .data_o    (wdata)
    );

    err_enable_reg #(.NSRC(NSRC), .EN_RESET(EN_RESET)) u_en (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op),
        .data_i (wdata),
        .en_o   (enable_o)
    );

    err_status_bank #(.NSRC(NSRC)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_i),
        .op_i     (op),
        .data_i   (wdata),
        .status_o (status_o)
    );

    err_irq_gen #(.NSRC(NSRC)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .status_i (status_o),
        .en_i     (enable_o),
        .irq_o    (irq_o),
        .term_o   (dma_term_o)
    );

endmodule

// File: rtl/err_irq_collector_chk.sv
module err_irq_collector_chk
    import err_coll_pkg::*;
#(
    parameter int NSRC   = SRC_COUNT,
    parameter int ADDR_W = ADDR_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   evt_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [NSRC-1:0]   wr_data_i,
    input logic [NSRC-1:0]   status_o,
    input logic [NSRC-1:0]   enable_o,
    input logic              irq_o,
    input logic              dma_term_o
);

    logic clr_now;
    logic spare_wr;

    assign clr_now  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CLEAR));
    assign spare_wr = wr_en_i && (wr_addr_i > ADDR_W'(ADDR_CLEAR));

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (status_o == '0 && !irq_o && !dma_term_o));

    // Also covers R8: the pulse wins over a clear in the same cycle.
    p_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !clr_now |=> (($past(status_o) & ~status_o) == '0));

    p_irq_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !wr_en_i) |=> irq_o);

    p_term_once_r6: assert property (@(posedge clk) disable iff (rst)
        dma_term_o |=> !dma_term_o);

    p_term_irq_r6: assert property (@(posedge clk) disable iff (rst)
        dma_term_o |-> irq_o);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_now && evt_i == '0) |=> ((status_o & $past(wr_data_i)) == '0));

    p_spare_addr_r10: assert property (@(posedge clk) disable iff (rst)
        (spare_wr && evt_i == '0) |=> ($stable(status_o) && $stable(enable_o)));

endmodule

bind err_irq_collector err_irq_collector_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .status_o   (status_o),
    .enable_o   (enable_o),
    .irq_o      (irq_o),
    .dma_term_o (dma_term_o)
);

// File: tb/err_irq_collector_tb.sv
`timescale 1ns/1ps
module err_irq_collector_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt = '0;
    logic       we = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] status, enable;
    logic       irq, term;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    err_irq_collector u_dut (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .wr_en_i    (we),
        .wr_addr_i  (addr),
        .wr_data_i  (wdata),
        .status_o   (status),
        .enable_o   (enable),
        .irq_o      (irq),
        .dma_term_o (term)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, then sample just after the capturing edge.
    task automatic step(input logic [7:0] e, input logic w,
                        input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        evt = e; we = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(8'h00, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "status in reset", status, 8'h00);
        chk("R1", "enable in reset", enable, 8'hFE);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "status after release", status, 8'h00);
        chk("R1", "irq after release", {7'b0, irq}, 8'h00);
        chk("R1", "term after release", {7'b0, term}, 8'h00);
    endtask

    task automatic t_latch_and_sticky();
        step(8'h04, 1'b0, 2'd0, 8'h00);
        chk("R2", "status after response timeout", status, 8'h04);
        chk("R4", "irq raised", {7'b0, irq}, 8'h01);
        chk("R6", "term pulse", {7'b0, term}, 8'h01);
        idle();
        chk("R3", "status holds", status, 8'h04);
        chk("R4", "irq holds", {7'b0, irq}, 8'h01);
        chk("R6", "term drops", {7'b0, term}, 8'h00);
        step(8'h80, 1'b0, 2'd0, 8'h00);
        chk("R2", "second source latched", status, 8'h84);
        chk("R6", "no second term pulse", {7'b0, term}, 8'h00);
    endtask

    task automatic t_clear();
        step(8'h00, 1'b1, 2'd1, 8'h04);
        chk("R7", "partial clear", status, 8'h80);
        chk("R4", "irq while one left", {7'b0, irq}, 8'h01);
        step(8'h00, 1'b1, 2'd1, 8'h80);
        chk("R7", "full clear", status, 8'h00);
        chk("R4", "irq drops after clear", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_disabled_source();
        step(8'h01, 1'b0, 2'd0, 8'h00);
        chk("R5", "card-irq status set", status, 8'h01);
        chk("R5", "no irq for disabled", {7'b0, irq}, 8'h00);
        chk("R5", "no term for disabled", {7'b0, term}, 8'h00);
        idle();
        chk("R5", "still no irq", {7'b0, irq}, 8'h00);
        step(8'h00, 1'b1, 2'd1, 8'h01);
        chk("R7", "card-irq cleared", status, 8'h00);
    endtask

    task automatic t_same_cycle();
        step(8'h08, 1'b0, 2'd0, 8'h00);
        step(8'h08, 1'b1, 2'd1, 8'h08);
        chk("R8", "event beats clear", status, 8'h08);
        idle();
        chk("R8", "bit kept", status, 8'h08);
        step(8'h00, 1'b1, 2'd1, 8'h08);
        chk("R7", "cleared afterwards", status, 8'h00);
    endtask

    task automatic t_enable_write();
        step(8'h00, 1'b1, 2'd0, 8'h00);
        chk("R9", "enable zeroed", enable, 8'h00);
        step(8'h10, 1'b0, 2'd0, 8'h00);
        chk("R2", "data crc latched", status, 8'h10);
        chk("R5", "no irq when all disabled", {7'b0, irq}, 8'h00);
        step(8'h00, 1'b1, 2'd0, 8'h10);
        chk("R9", "enable loaded", enable, 8'h10);
        chk("R9", "irq on late enable", {7'b0, irq}, 8'h01);
        chk("R9", "term on late enable", {7'b0, term}, 8'h01);
        idle();
        chk("R6", "term one cycle", {7'b0, term}, 8'h00);
    endtask

    task automatic t_spare_addr();
        step(8'h00, 1'b1, 2'd2, 8'hFF);
        chk("R10", "status after addr 2", status, 8'h10);
        chk("R10", "enable after addr 2", enable, 8'h10);
        step(8'h00, 1'b1, 2'd3, 8'hFF);
        chk("R10", "status after addr 3", status, 8'h10);
        chk("R10", "enable after addr 3", enable, 8'h10);
        step(8'h00, 1'b1, 2'd0, 8'hFE);
        step(8'h00, 1'b1, 2'd1, 8'hFF);
        chk("R7", "clear all", status, 8'h00);
    endtask

    task automatic t_all_sources();
        step(8'hFF, 1'b0, 2'd0, 8'h00);
        chk("R2", "all sources", status, 8'hFF);
        chk("R6", "term on burst", {7'b0, term}, 8'h01);
        step(8'h00, 1'b1, 2'd1, 8'hFE);
        chk("R7", "clear enabled ones", status, 8'h01);
        chk("R5", "irq off with only disabled left", {7'b0, irq}, 8'h00);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        t_reset();
        t_latch_and_sticky();
        t_clear();
        t_disabled_source();
        t_same_cycle();
        t_enable_write();
        t_spare_addr();
        t_all_sources();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule